// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

A 16-bit up-counter with two compare channels, A and B. Each channel owns a 2-bit action code and turns counter/compare coincidences into a level on its own output pin. The active counting scheme is chosen by a 4-bit mode selector. The two low selector bits live in a byte-wide control register. The two high bits arrive on a separate input.

The selector picks one of three families. In the free-running family the counter wraps from 0xFFFF to 0. In the clear-on-match family the counter returns to 0 after reaching the TOP input. In the fast PWM family the counter runs from 0 to a TOP value and wraps, and each output is driven at the compare point and again at the wrap. In fast PWM the compare values are double-buffered so that a period is never cut short.

A channel takes over its pin only when its code is active for the current family. The pin is driven only when the channel's direction bit is also set.

Top module: `cmp_wave_unit`

## Requirements
- R1: The control byte holds channel A's code in bits 7:6, channel B's code in bits 5:4, and the low selector bits in 1:0. Bits 3:2 always read as 0. The whole byte reads 0 after reset, and a write is visible on the read port from the next cycle.
- R2: Outside fast PWM, code 00 leaves the channel's override flag low, and any nonzero code raises it.
- R3: A pin's output enable is high only when its override flag and its direction bit are both set. While the enable is low, the pin output reads 0.
- R4: Outside fast PWM, a counting cycle on which the count equals the compare value has the following effect from the next cycle: code 01 toggles the output, code 10 drives it to 0, and code 11 drives it to 1.
- R5: The counter advances by one on each cycle where the count enable is high, and holds while the enable is low. Selector values 4 and 12 are clear-on-match: the cycle after the count equals TOP it reads 0. Every selector value outside 4, 5, 6, 7, 12, 14 and 15 counts freely through 0xFFFF.
- R6: Selector values 5, 6, 7, 14 and 15 are fast PWM. Code 10 drives the output to 0 at the compare point and to 1 on the wrap cycle. Code 11 does the reverse.
- R7: In fast PWM, code 01 makes channel A toggle at the compare point only when the selector is 14 or 15, and its override flag is then high. Channel B with code 01 stays disconnected, with its flag low. With any other fast PWM selector, code 01 leaves both flags low.
- R8: In fast PWM with code 10 or 11, a compare value equal to TOP produces no compare action. The output changes only on the wrap, to the level the code gives there.
- R9: In fast PWM, a new compare input takes effect only after the next wrap. Outside fast PWM it takes effect on the next counting cycle.
- R10: The fast PWM TOP is 255 for selector 5, 511 for 6, 1023 for 7, and the TOP input for 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte read data |
| mode_hi | input | 2 | Upper two bits of the mode selector |
| top_in | input | 16 | TOP value for selectors 4, 12, 14, 15 |
| cmp_a_in | input | 16 | Compare value, channel A |
| cmp_b_in | input | 16 | Compare value, channel B |
| cnt_en | input | 1 | Count enable (counting cycle) |
| dir_a | input | 1 | Direction enable, pin A |
| dir_b | input | 1 | Direction enable, pin B |
| cnt_o | output | 16 | Current count |
| pin_a_o | output | 1 | Pin A level |
| pin_a_oe | output | 1 | Pin A driver enable |
| ovr_a | output | 1 | Channel A owns pin A |
| pin_b_o | output | 1 | Pin B level |
| pin_b_oe | output | 1 | Pin B driver enable |
| ovr_b | output | 1 | Channel B owns pin B |

## Verification
The bench changes the channel A compare input partway through a fast PWM period. A design that compared against the live input instead of the buffered copy would miss a pending match, or take one too early, and the pin would hold the wrong level for that period.

Compare values equal to TOP are run for both the non-inverting and the inverting code. A unit that let the match act there would return the pin to the opposite level instead of keeping a 100% or 0% duty.

Code 01 is tried under selectors 15, 14 and 5 so that a toggle leaking onto channel B or into the wrong fast PWM mode shows on the override flags. The clear-on-match and fixed-TOP runs count exact cycles to the wrap, which exposes any off-by-one in the TOP comparison.

// File: rtl/cwu_pkg.sv
package cwu_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        FAM_FREE = 2'd0,
        FAM_CTC  = 2'd1,
        FAM_FAST = 2'd2
    } fam_e;

    localparam logic [1:0] ACT_OFF = 2'b00;
    localparam logic [1:0] ACT_TGL = 2'b01;
    localparam logic [1:0] ACT_CLR = 2'b10;
    localparam logic [1:0] ACT_SET = 2'b11;

    typedef struct packed {
        logic [1:0] code_a;
        logic [1:0] code_b;
        logic [1:0] mode_lo;
    } cfg_t;
endpackage

// File: rtl/cwu_mode_dec.sv
module cwu_mode_dec
    import cwu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   sel,
    input  logic [W-1:0] top_in,
    output fam_e         fam,
    output logic [W-1:0] top,
    output logic         alt_tgl
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [W-1:0] TOP_8  = W'(32'h0000_00FF);
    localparam logic [W-1:0] TOP_9  = W'(32'h0000_01FF);
    localparam logic [W-1:0] TOP_10 = W'(32'h0000_03FF);

    always_comb begin
        fam = FAM_FREE;
        top = '1;
        unique case (sel)
            4'd4, 4'd12: begin fam = FAM_CTC;  top = top_in; end
            4'd5:        begin fam = FAM_FAST; top = TOP_8;  end
            4'd6:        begin fam = FAM_FAST; top = TOP_9;  end
            4'd7:        begin fam = FAM_FAST; top = TOP_10; end
            4'd14, 4'd15: begin fam = FAM_FAST; top = top_in; end
            default:     begin fam = FAM_FREE; top = '1;     end
        endcase
        alt_tgl = (sel == 4'd14) || (sel == 4'd15);
    end
endmodule

// File: rtl/cwu_counter.sv
module cwu_counter
    import cwu_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_en,
    input  fam_e                    fam,
    input  logic [W-1:0]            top,
    input  logic [NCH-1:0][W-1:0]   cmp_in,
    output logic [W-1:0]            cnt,
    output logic                    wrap,
    output logic [NCH-1:0][W-1:0]   cmp_eff
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [W-1:0]          cnt;
        logic [NCH-1:0][W-1:0] hold;
    } cst_t;

    cst_t st_d, st_q;
    logic at_top;

    always_comb begin
        at_top = (fam != FAM_FREE) && (st_q.cnt >= top);
        st_d   = st_q;
        if (cnt_en) begin
            st_d.cnt = at_top ? '0 : st_q.cnt + 1'b1;
        end
        for (int i = 0; i < NCH; i++) begin
            if (fam != FAM_FAST) begin
                st_d.hold[i] = cmp_in[i];
            end else if (cnt_en && at_top) begin
                st_d.hold[i] = cmp_in[i];
            end
            cmp_eff[i] = (fam == FAM_FAST) ? st_q.hold[i] : cmp_in[i];
        end
        cnt  = st_q.cnt;
        wrap = at_top;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WRAP_TO_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && wrap) |=> (cnt == '0)); // R5
    AST_COUNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en) |=> $stable(cnt)); // R5
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ((fam == FAM_FAST) && !(cnt_en && wrap)) |=> $stable(st_q.hold)); // R9
endmodule

// File: rtl/cwu_channel.sv
module cwu_channel
    import cwu_pkg::*;
#(
    parameter int W      = 16,
    parameter bit ALT_OK = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  fam_e         fam,
    input  logic [1:0]   code,
    input  logic         alt_tgl,
    input  logic [W-1:0] cnt,
    input  logic         wrap,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] top,
    output logic         oc,
    output logic         ovr
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic oc;
    } chs_t;

    chs_t st_d, st_q;
    logic hit, fast, alt;

    always_comb begin
        hit  = (cnt == cmp);
        fast = (fam == FAM_FAST);
        alt  = ALT_OK && alt_tgl;
        ovr  = (code != ACT_OFF) && (!fast || code[1] || alt);
        st_d = st_q;
        if (cnt_en) begin
            if (!fast) begin
                if (hit) begin
                    unique case (code)
                        ACT_TGL: st_d.oc = ~st_q.oc;
                        ACT_CLR: st_d.oc = 1'b0;
                        ACT_SET: st_d.oc = 1'b1;
                        default: st_d.oc = st_q.oc;
                    endcase
                end
            end else if (code[1]) begin
                if (wrap)                    st_d.oc = (code == ACT_CLR);
                else if (hit && (cmp != top)) st_d.oc = (code == ACT_SET);
            end else if ((code == ACT_TGL) && alt && hit) begin
                st_d.oc = ~st_q.oc;
            end
        end
        oc = st_q.oc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PLAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !fast && (code == ACT_CLR) && hit) |=> !oc); // R4
    AST_PLAIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !fast && (code == ACT_SET) && hit) |=> oc); // R4
    AST_BOTTOM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && fast && code[1] && wrap) |=> (oc == ($past(code) == ACT_CLR))); // R6
    AST_TOP_MATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && fast && code[1] && (cmp == top) && !wrap) |=> $stable(oc)); // R8
    AST_PWM_DISCONNECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && (code == ACT_TGL) && !alt) |=> $stable(oc)); // R7
endmodule

// File: rtl/cmp_wave_unit.sv
module cmp_wave_unit
    import cwu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [7:0]   cfg_wdata,
    output logic [7:0]   cfg_rdata,
    input  logic [1:0]   mode_hi,
    input  logic [W-1:0] top_in,
    input  logic [W-1:0] cmp_a_in,
    input  logic [W-1:0] cmp_b_in,
    input  logic         cnt_en,
    input  logic         dir_a,
    input  logic         dir_b,
    output logic [W-1:0] cnt_o,
    output logic         pin_a_o,
    output logic         pin_a_oe,
    output logic         ovr_a,
    output logic         pin_b_o,
    output logic         pin_b_oe,
    output logic         ovr_b
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 2;

    cfg_t cfg_d, cfg_q;
    logic unused_rsvd;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.code_a  = cfg_wdata[7:6];
            cfg_d.code_b  = cfg_wdata[5:4];
            cfg_d.mode_lo = cfg_wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign unused_rsvd = ^cfg_wdata[3:2];
    assign cfg_rdata   = {cfg_q.code_a, cfg_q.code_b, 2'b00, cfg_q.mode_lo};

    fam_e                  fam;
    logic [W-1:0]          top;
    logic                  alt_tgl;
    logic [W-1:0]          cnt;
    logic                  wrap;
    logic [NCH-1:0][W-1:0] cmp_in_arr, cmp_eff;
    logic [NCH-1:0][1:0]   code_arr;
    logic [NCH-1:0]        oc, ovr, dir, pin_oe, pin_v;

    assign cmp_in_arr = {cmp_b_in, cmp_a_in};
    assign code_arr   = {cfg_q.code_b, cfg_q.code_a};
    assign dir        = {dir_b, dir_a};

    cwu_mode_dec #(.W(W)) u_dec (
        .sel     ({mode_hi, cfg_q.mode_lo}),
        .top_in  (top_in),
        .fam     (fam),
        .top     (top),
        .alt_tgl (alt_tgl)
    );

    cwu_counter #(.W(W), .NCH(NCH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .fam     (fam),
        .top     (top),
        .cmp_in  (cmp_in_arr),
        .cnt     (cnt),
        .wrap    (wrap),
        .cmp_eff (cmp_eff)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cwu_channel #(.W(W), .ALT_OK(g == 0)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_en  (cnt_en),
            .fam     (fam),
            .code    (code_arr[g]),
            .alt_tgl (alt_tgl),
            .cnt     (cnt),
            .wrap    (wrap),
            .cmp     (cmp_eff[g]),
            .top     (top),
            .oc      (oc[g]),
            .ovr     (ovr[g])
        );
        assign pin_oe[g] = ovr[g] & dir[g];
        assign pin_v[g]  = pin_oe[g] & oc[g];
    end

    assign cnt_o    = cnt;
    assign pin_a_o  = pin_v[0];
    assign pin_a_oe = pin_oe[0];
    assign ovr_a    = ovr[0];
    assign pin_b_o  = pin_v[1];
    assign pin_b_oe = pin_oe[1];
    assign ovr_b    = ovr[1];

    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == {$past(cfg_wdata[7:4]), 2'b00, $past(cfg_wdata[1:0])})); // R1
endmodule

// File: tb/cmp_wave_unit_bench.sv
module cmp_wave_unit_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk, rst_n, cfg_we, cnt_en, dir_a, dir_b;
    logic [7:0]  cfg_wdata, cfg_rdata;
    logic [1:0]  mode_hi;
    logic [15:0] top_in, cmp_a_in, cmp_b_in, cnt_o;
    logic        pin_a_o, pin_a_oe, ovr_a, pin_b_o, pin_b_oe, ovr_b;

    int n_chk = 0;
    int n_err = 0;

    cmp_wave_unit u_cmp_wave_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mode_hi(mode_hi), .top_in(top_in),
        .cmp_a_in(cmp_a_in), .cmp_b_in(cmp_b_in), .cnt_en(cnt_en),
        .dir_a(dir_a), .dir_b(dir_b), .cnt_o(cnt_o),
        .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe), .ovr_a(ovr_a),
        .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe), .ovr_b(ovr_b)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        cnt_en = 1'b0; cfg_we = 1'b0;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
    endtask

    task automatic wr_cfg(input logic [7:0] b);
        cfg_we = 1'b1; cfg_wdata = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "rdata after reset", cfg_rdata, 8'h00);
        chk("R5", "count after reset", cnt_o, 16'h0);
        chk("R2", "flag A after reset", ovr_a, 1'b0);
        chk("R3", "enable B after reset", pin_b_oe, 1'b0);
    endtask

    task automatic t_register();
        do_reset();
        wr_cfg(8'hFF);
        chk("R1", "reserved bits read zero", cfg_rdata, 8'hF3);
        wr_cfg(8'h0C);
        chk("R1", "only reserved bits written", cfg_rdata, 8'h00);
        wr_cfg(8'hA6);
        chk("R1", "mixed write", cfg_rdata, 8'hA2);
        do_reset();
        chk("R1", "reset clears byte", cfg_rdata, 8'h00);
    endtask

    task automatic t_plain();
        do_reset();
        mode_hi = 2'b00; cmp_a_in = 16'd5; cmp_b_in = 16'd3;
        dir_a = 1'b0; dir_b = 1'b1;
        wr_cfg(8'hD0);
        chk("R2", "flag A with code 11", ovr_a, 1'b1);
        chk("R2", "flag B with code 01", ovr_b, 1'b1);
        chk("R3", "enable A without direction", pin_a_oe, 1'b0);
        run(4);
        chk("R5", "count after 4", cnt_o, 16'd4);
        chk("R4", "B toggled at match", pin_b_o, 1'b1);
        run(2);
        chk("R3", "pin A quiet without direction", pin_a_o, 1'b0);
        dir_a = 1'b1; #1;
        chk("R4", "A set at match", pin_a_o, 1'b1);
        chk("R3", "enable A with direction", pin_a_oe, 1'b1);
        @(negedge clk);
        cmp_a_in = 16'd7;
        wr_cfg(8'h90);
        run(2);
        chk("R9", "A cleared at new compare at once", pin_a_o, 1'b0);
        chk("R4", "B unchanged", pin_b_o, 1'b1);
        repeat (3) @(negedge clk);
        chk("R5", "count holds when disabled", cnt_o, 16'd8);
        wr_cfg(8'h00);
        chk("R2", "flag A code 00", ovr_a, 1'b0);
        chk("R3", "enable B code 00", pin_b_oe, 1'b0);
    endtask

    task automatic t_ctc();
        mode_hi = 2'b01; top_in = 16'd9; cmp_a_in = 16'd9;
        dir_a = 1'b1; dir_b = 1'b1;
        do_reset();
        wr_cfg(8'h40);
        run(10);
        chk("R5", "clear-on-match wrap", cnt_o, 16'd0);
        chk("R4", "toggle at TOP", pin_a_o, 1'b1);
        run(5);
        chk("R5", "mid period count", cnt_o, 16'd5);
        run(5);
        chk("R5", "second wrap", cnt_o, 16'd0);
        chk("R4", "second toggle", pin_a_o, 1'b0);
        mode_hi = 2'b11;
        run(10);
        chk("R5", "selector 12 wraps at TOP", cnt_o, 16'd0);
        chk("R4", "selector 12 toggle", pin_a_o, 1'b1);
    endtask

    task automatic t_fast();
        mode_hi = 2'b11; top_in = 16'd9; cmp_a_in = 16'd3; cmp_b_in = 16'd3;
        dir_a = 1'b1; dir_b = 1'b1;
        do_reset();
        wr_cfg(8'hB2);
        run(4);
        chk("R6", "non-inverting low at match", pin_a_o, 1'b0);
        chk("R6", "inverting high at match", pin_b_o, 1'b1);
        run(6);
        chk("R10", "selector 14 wraps at TOP input", cnt_o, 16'd0);
        chk("R6", "non-inverting high at wrap", pin_a_o, 1'b1);
        chk("R6", "inverting low at wrap", pin_b_o, 1'b0);
        run(4);
        chk("R6", "non-inverting low again", pin_a_o, 1'b0);
        cmp_a_in = 16'd1;
        run(6);
        chk("R6", "high after wrap", pin_a_o, 1'b1);
        cmp_a_in = 16'd7;
        run(2);
        chk("R9", "buffered compare 1 still in force", pin_a_o, 1'b0);
        run(8);
        chk("R6", "high after next wrap", pin_a_o, 1'b1);
        run(7);
        chk("R9", "compare 7 not yet reached", pin_a_o, 1'b1);
        run(1);
        chk("R9", "compare 7 taken after wrap", pin_a_o, 1'b0);
    endtask

    task automatic t_top_ignore();
        mode_hi = 2'b11; top_in = 16'd9; cmp_a_in = 16'd9; cmp_b_in = 16'd9;
        dir_a = 1'b1; dir_b = 1'b1;
        do_reset();
        wr_cfg(8'hB2);
        run(10);
        chk("R8", "A set by wrap", pin_a_o, 1'b1);
        chk("R8", "B cleared by wrap", pin_b_o, 1'b0);
        run(9);
        chk("R8", "A holds across period", pin_a_o, 1'b1);
        run(1);
        chk("R8", "A stays high, match at TOP ignored", pin_a_o, 1'b1);
        chk("R8", "B stays low, match at TOP ignored", pin_b_o, 1'b0);
    endtask

    task automatic t_alt();
        mode_hi = 2'b11; top_in = 16'd9; cmp_a_in = 16'd9; cmp_b_in = 16'd9;
        dir_a = 1'b1; dir_b = 1'b1;
        do_reset();
        wr_cfg(8'h53);
        chk("R7", "A owns pin in selector 15", ovr_a, 1'b1);
        chk("R7", "B disconnected with code 01", ovr_b, 1'b0);
        chk("R7", "B enable low", pin_b_oe, 1'b0);
        run(10);
        chk("R7", "A toggles at match", pin_a_o, 1'b1);
        run(10);
        chk("R7", "A toggles back", pin_a_o, 1'b0);
        wr_cfg(8'h52);
        run(10);
        chk("R7", "A toggles in selector 14", pin_a_o, 1'b1);
        mode_hi = 2'b01;
        wr_cfg(8'h51);
        chk("R7", "A disconnected in selector 5", ovr_a, 1'b0);
        chk("R7", "A enable low in selector 5", pin_a_oe, 1'b0);
        chk("R7", "B disconnected in selector 5", ovr_b, 1'b0);
    endtask

    task automatic t_tops();
        mode_hi = 2'b01;
        do_reset();
        wr_cfg(8'h01);
        run(255);
        chk("R10", "selector 5 reaches 255", cnt_o, 16'd255);
        run(1);
        chk("R10", "selector 5 wraps", cnt_o, 16'd0);
        wr_cfg(8'h02);
        run(511);
        chk("R10", "selector 6 reaches 511", cnt_o, 16'd511);
        run(1);
        chk("R10", "selector 6 wraps", cnt_o, 16'd0);
        wr_cfg(8'h03);
        run(1023);
        chk("R10", "selector 7 reaches 1023", cnt_o, 16'd1023);
        run(1);
        chk("R10", "selector 7 wraps", cnt_o, 16'd0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00; cnt_en = 1'b0;
        mode_hi = 2'b00; top_in = 16'h0; cmp_a_in = 16'h0; cmp_b_in = 16'h0;
        dir_a = 1'b0; dir_b = 1'b0;
        @(negedge clk);
        t_reset();
        t_register();
        t_plain();
        t_ctc();
        t_fast();
        t_top_ignore();
        t_alt();
        t_tops();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule